// File: doc/BRIEF.md
# Time-Domain-Integration Grayscale Exposure Array

This block models, at register level, a strip of binary exposure cells that builds up a gray dose by time-domain integration. Each pixel row accepts a 5-bit gray value on every accepted line. The value is split into its bits, and each bit lights a group of columns whose width is proportional to the weight of that bit. The lit pattern moves one column per accepted line, in step with the substrate moving under the array. A given spot therefore meets the same pixel's lit cells in every column it crosses, and the number of lit cells it meets equals its gray value times the unit width `N_UNIT`.

The column groups for bits 1 to 4 are each cut in half. The halves are placed as mirror images about the array's centre, and the unsplit bit-0 group sits at the centre. Ring-buffer delay lines align each bit to the first column of its group, carry it across the gap between its two halves, and hold it after it leaves the array so that all five bits of a pixel come out together. A reference copy of the input, delayed by the same number of lines, is compared with the rebuilt value, and any difference sets a sticky per-row fault flag. A line-advance input gates every register and delay line, so a stall freezes the whole pattern.

Top module: `tdi_exposure_array`

## Requirements
- R1: The array is `31*N_UNIT` columns wide, numbered 0 at the entry side. In units of `N_UNIT`, column c shows bit 4 of its pixel for unit positions 0–7 and 23–30, bit 3 for 8–11 and 19–22, bit 2 for 12–13 and 17–18, bit 1 for 14 and 16, and bit 0 for 15.
- R2: On each clock edge with `line_adv` high, every column moves one step. After the k-th accepted line (k counted from 0 since reset), column c of a row shows the bit named in R1 of the gray value that row accepted on line k−c, or 0 if k−c < 0. Cell c of row r is `mirror_on[r*31*N_UNIT + c]`, and gray bit b of row r is `gray_in[r*5 + b]`.
- R3: The number of lit cells a pixel meets over its 31·N_UNIT lines in the array equals its gray value times `N_UNIT`, for every gray value from 0 to 31.
- R4: After the k-th accepted line, `gray_rebuilt` for a row equals the value that row accepted on line k − 31·N_UNIT, or 0 if no such line exists.
- R5: While `line_adv` is low, `gray_in` is ignored, and `mirror_on` and `gray_rebuilt` keep their values.
- R6: `row_fault[r]` goes high when row r's rebuilt value differs from its delayed reference, and stays high until reset. In fault-free operation it stays 0.
- R7: After a synchronous reset (`rst_n` low at a clock edge), all cells are off, `gray_rebuilt` is 0 and `row_fault` is 0. This holds both at start-up and after a reset in mid-run.
- R8: Rows are independent. Each row's cells and rebuilt value depend only on that row's own gray inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_adv | input | 1 | Accept one line and advance all columns and delay lines |
| gray_in | input | ROWS*5 | Gray value per row, row r at bits [r*5 +: 5] |
| mirror_on | output | ROWS*31*N_UNIT | Cell state, row r column c at bit r*31*N_UNIT + c |
| gray_rebuilt | output | ROWS*5 | Reassembled gray value per row after the full array delay |
| row_fault | output | ROWS | Sticky mismatch flag per row |

## Verification
Entry of a new pixel at column 0 and the exit of a pixel accepted 31·N_UNIT lines earlier take place on the same advance. The bit planes of many pixels also move through their bridge delays in the same cycles. The bench runs more than three array lengths of lines with gray ramps, reversed ramps, a scrambled sequence and a square wave of 0 and 31 on different rows, with stalls mixed in. This keeps entry, bridging and exit all active together. After every edge the bench compares every cell, the rebuilt value, each finished pixel's accumulated dose and the fault flags against a line-indexed history of the inputs.

// File: rtl/tdi_pkg.sv
// Package: column-group geometry of the time-domain-integration array.
// Assumes bit k owns two halves of 2^(k-1)*n columns (k>=1), mirrored about
// the centre, with the n-column bit-0 group in the middle.
package tdi_pkg;

    // Total column count for b gray bits and unit width n.
    function automatic int array_width(int n, int b);
        return n * ((1 << b) - 1);
    endfunction

    // First column of the entry-side group of bit k.
    function automatic int first_start(int k, int n, int b);
        return n * ((1 << (b - 1)) - (1 << k));
    endfunction

    // Last column of the entry-side group of bit k.
    function automatic int first_end(int k, int n, int b);
        if (k == 0) return n * (1 << (b - 1)) - 1;
        return n * ((1 << (b - 1)) - (1 << (k - 1))) - 1;
    endfunction

    // First column of the exit-side half of bit k (k >= 1).
    function automatic int second_start(int k, int n, int b);
        return n * ((1 << (b - 1)) + (1 << (k - 1)) - 1);
    endfunction

    // Last column lit by bit k.
    function automatic int last_end(int k, int n, int b);
        if (k == 0) return n * (1 << (b - 1)) - 1;
        return n * ((1 << (b - 1)) + (1 << k) - 1) - 1;
    endfunction

    // 0: column fed by its left neighbour, 1: fed by an entry delay, 2: by a bridge.
    function automatic int col_kind(int c, int n, int b);
        for (int k = 0; k < b; k++) begin
            if (c == first_start(k, n, b)) return 1;
            if (k > 0 && c == second_start(k, n, b)) return 2;
        end
        return 0;
    endfunction

    // Bit whose delay line feeds column c (meaningful when col_kind != 0).
    function automatic int col_bit(int c, int n, int b);
        for (int k = 0; k < b; k++) begin
            if (c == first_start(k, n, b)) return k;
            if (k > 0 && c == second_start(k, n, b)) return k;
        end
        return 0;
    endfunction

endpackage

// File: rtl/tdi_delay_ring.sv
// Ring-buffer delay line: dout shows the din written DEPTH enabled cycles ago.
// Assumes DEPTH >= 1; a zero-length delay is a wire and is not instantiated.
module tdi_delay_ring #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    ptr;

    // Write the new entry over the oldest one and advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (en) begin
            mem[ptr] <= din;
            ptr      <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
        end
    end

    assign dout = mem[ptr];
endmodule

// File: rtl/tdi_row.sv
// One pixel row: entry delays, shifting cell columns, bridge delays between
// split halves, exit delays, reassembly and sticky compare with a reference.
// Assumes gray_in is sampled only when adv is high.
module tdi_row #(
    parameter int N_UNIT    = 8,
    parameter int GRAY_BITS = 5,
    localparam int W        = tdi_pkg::array_width(N_UNIT, GRAY_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic [GRAY_BITS-1:0] gray_in,
    output logic [W-1:0]         cells,
    output logic [GRAY_BITS-1:0] gray_out,
    output logic                 fault
);
    import tdi_pkg::*;

    logic [W-1:0]         col_q, col_d;
    logic [GRAY_BITS-1:0] entry_v, exit_v, out_q, ref_v, ref_q;
    logic [GRAY_BITS-1:1] bridge_v;
    logic                 fault_q;

    // Per-bit entry, bridge and exit delay lines.
    for (genvar k = 0; k < GRAY_BITS; k++) begin : g_bit
        localparam int ENT_D = first_start(k, N_UNIT, GRAY_BITS);
        localparam int LE    = last_end(k, N_UNIT, GRAY_BITS);
        localparam int EXT_D = W - 1 - LE;

        if (ENT_D == 0) begin : g_ent_wire
            assign entry_v[k] = gray_in[k];
        end else begin : g_ent_ring
            tdi_delay_ring #(.WIDTH(1), .DEPTH(ENT_D)) ent_i (
                .clk(clk), .rst_n(rst_n), .en(adv),
                .din(gray_in[k]), .dout(entry_v[k]));
        end

        if (k > 0) begin : g_bridge
            localparam int FE    = first_end(k, N_UNIT, GRAY_BITS);
            localparam int BRG_D = second_start(k, N_UNIT, GRAY_BITS) - FE - 1;
            tdi_delay_ring #(.WIDTH(1), .DEPTH(BRG_D)) brg_i (
                .clk(clk), .rst_n(rst_n), .en(adv),
                .din(col_q[FE]), .dout(bridge_v[k]));
        end

        if (EXT_D == 0) begin : g_ext_wire
            assign exit_v[k] = col_q[LE];
        end else begin : g_ext_ring
            tdi_delay_ring #(.WIDTH(1), .DEPTH(EXT_D)) ext_i (
                .clk(clk), .rst_n(rst_n), .en(adv),
                .din(col_q[LE]), .dout(exit_v[k]));
        end
    end

    // Column input selection: group start points take a delay output.
    for (genvar c = 0; c < W; c++) begin : g_col
        localparam int KIND = col_kind(c, N_UNIT, GRAY_BITS);
        localparam int KB   = col_bit(c, N_UNIT, GRAY_BITS);
        if (KIND == 1) begin : g_from_entry
            assign col_d[c] = entry_v[KB];
        end else if (KIND == 2) begin : g_from_bridge
            assign col_d[c] = bridge_v[KB];
        end else begin : g_from_left
            assign col_d[c] = col_q[c-1];
        end
    end

    // Reference copy of the input, delayed by the full array length.
    tdi_delay_ring #(.WIDTH(GRAY_BITS), .DEPTH(W)) ref_i (
        .clk(clk), .rst_n(rst_n), .en(adv), .din(gray_in), .dout(ref_v));

    // Shift the cells and capture the reassembled and reference values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            out_q <= '0;
            ref_q <= '0;
        end else if (adv) begin
            col_q <= col_d;
            out_q <= exit_v;
            ref_q <= ref_v;
        end
    end

    // Sticky mismatch flag between the rebuilt and the reference value.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fault_q | (out_q != ref_q);
    end

    assign cells    = col_q;
    assign gray_out = out_q;
    assign fault    = fault_q;
endmodule

// File: rtl/tdi_exposure_array.sv
// Top: ROWS independent TDI pixel rows sharing one line-advance strobe.
// Assumes row r uses slices [r*GRAY_BITS +: GRAY_BITS] and [r*W +: W].
module tdi_exposure_array #(
    parameter int ROWS      = 4,
    parameter int N_UNIT    = 8,
    parameter int GRAY_BITS = 5,
    localparam int W        = tdi_pkg::array_width(N_UNIT, GRAY_BITS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_adv,
    input  logic [ROWS*GRAY_BITS-1:0] gray_in,
    output logic [ROWS*W-1:0]         mirror_on,
    output logic [ROWS*GRAY_BITS-1:0] gray_rebuilt,
    output logic [ROWS-1:0]           row_fault
);
    // One row instance per pixel row.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        tdi_row #(.N_UNIT(N_UNIT), .GRAY_BITS(GRAY_BITS)) row_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (line_adv),
            .gray_in (gray_in[r*GRAY_BITS +: GRAY_BITS]),
            .cells   (mirror_on[r*W +: W]),
            .gray_out(gray_rebuilt[r*GRAY_BITS +: GRAY_BITS]),
            .fault   (row_fault[r]));
    end
endmodule

// File: rtl/tdi_exposure_array_chk.sv
// Checker for tdi_exposure_array: shift, stall, entry and fault-flag rules.
module tdi_exposure_array_chk #(
    parameter int ROWS      = 4,
    parameter int N_UNIT    = 8,
    parameter int GRAY_BITS = 5,
    localparam int W        = tdi_pkg::array_width(N_UNIT, GRAY_BITS)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      line_adv,
    input logic [ROWS*GRAY_BITS-1:0] gray_in,
    input logic [ROWS*W-1:0]         mirror_on,
    input logic [ROWS*GRAY_BITS-1:0] gray_rebuilt,
    input logic [ROWS-1:0]           row_fault
);
    // Columns that take their value from the left neighbour.
    function automatic logic [ROWS*W-1:0] chain_mask();
        logic [ROWS*W-1:0] m = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < W; c++)
                m[r*W + c] = (tdi_pkg::col_kind(c, N_UNIT, GRAY_BITS) == 0);
        return m;
    endfunction
    localparam logic [ROWS*W-1:0] CHAIN = chain_mask();

    AST_CELLS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        line_adv |=> ((mirror_on & CHAIN) == (($past(mirror_on) << 1) & CHAIN))); // R2
    AST_CELLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_adv |=> $stable(mirror_on)); // R5
    AST_REBUILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_adv |=> $stable(gray_rebuilt)); // R5
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (row_fault != '0) |=> ((row_fault & $past(row_fault)) == $past(row_fault))); // R6
    AST_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        row_fault == '0); // R6

    for (genvar r = 0; r < ROWS; r++) begin : g_entry
        AST_TOP_BIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            line_adv |=> (mirror_on[r*W] == $past(gray_in[r*GRAY_BITS + GRAY_BITS - 1]))); // R1
    end
endmodule

bind tdi_exposure_array tdi_exposure_array_chk #(
    .ROWS(ROWS), .N_UNIT(N_UNIT), .GRAY_BITS(GRAY_BITS)) chk_i (.*);

// File: tb/tdi_exposure_array_tb_top.sv
// Bench: drives ramps, scrambled and square-wave gray streams with stalls,
// and checks every cell, rebuilt value, dose and fault flag against history.
module tdi_exposure_array_tb_top;
    localparam int ROWS = 4;
    localparam int NU   = 8;
    localparam int GB   = 5;
    localparam int W    = 31 * NU;
    localparam int HMAX = 2048;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 line_adv = 1'b0;
    logic [ROWS*GB-1:0]   gray_in = '0;
    logic [ROWS*W-1:0]    mirror_on;
    logic [ROWS*GB-1:0]   gray_rebuilt;
    logic [ROWS-1:0]      row_fault;

    int n_chk = 0;
    int n_bad = 0;
    int cnt   = 0;
    int hist [ROWS][HMAX];
    int dose [ROWS][HMAX];

    always #5 clk = ~clk;

    tdi_exposure_array #(.ROWS(ROWS), .N_UNIT(NU), .GRAY_BITS(GB)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_adv(line_adv), .gray_in(gray_in),
        .mirror_on(mirror_on), .gray_rebuilt(gray_rebuilt), .row_fault(row_fault));

    // Column owner bit, from the unit-position ranges of R1.
    function automatic int owner(int c);
        int u = c / NU;
        if (u < 8)  return 4;
        if (u < 12) return 3;
        if (u < 14) return 2;
        if (u < 15) return 1;
        if (u < 16) return 0;
        if (u < 17) return 1;
        if (u < 19) return 2;
        if (u < 23) return 3;
        return 4;
    endfunction

    function automatic int pattern(int r, int a);
        case (r)
            0: return a % 32;
            1: return 31 - (a % 32);
            2: return (a * 13 + 7) % 32;
            default: return ((a / 5) % 2) ? 31 : 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare all outputs with the model after the last edge.
    task automatic check_all(input bit advanced);
        for (int r = 0; r < ROWS; r++) begin
            int pr = cnt - 1 - W;
            int eg = (pr >= 0) ? hist[r][pr] : 0;
            for (int c = 0; c < W; c++) begin
                int p = cnt - 1 - c;
                int e = (p >= 0) ? ((hist[r][p] >> owner(c)) & 1) : 0;
                int a = int'(mirror_on[r*W + c]);
                chk(a == e, advanced ? "R2 R1 R8 cell" : "R5 cell hold", a, e);
                if (advanced && p >= 0) begin
                    dose[r][p] += a;
                    if (c == W - 1)
                        chk(dose[r][p] == hist[r][p] * NU, "R3 dose", dose[r][p], hist[r][p] * NU);
                end
            end
            chk(int'(gray_rebuilt[r*GB +: GB]) == eg, advanced ? "R4 rebuilt" : "R5 rebuilt hold",
                int'(gray_rebuilt[r*GB +: GB]), eg);
        end
        chk(row_fault == '0, "R6 fault flag", int'(row_fault), 0);
    endtask

    task automatic step(input bit adv);
        line_adv = adv;
        for (int r = 0; r < ROWS; r++)
            gray_in[r*GB +: GB] = adv ? GB'(pattern(r, cnt)) : GB'($urandom_range(31));
        @(negedge clk);
        if (adv) begin
            for (int r = 0; r < ROWS; r++) hist[r][cnt] = pattern(r, cnt);
            cnt++;
        end
        check_all(adv);
    endtask

    task automatic check_reset();
        chk(mirror_on == '0, "R7 cells off", int'($countones(mirror_on)), 0);
        chk(gray_rebuilt == '0, "R7 rebuilt zero", int'(gray_rebuilt), 0);
        chk(row_fault == '0, "R7 fault clear", int'(row_fault), 0);
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int i = 0; i < HMAX; i++) begin
                hist[r][i] = 0;
                dose[r][i] = 0;
            end
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 960; cyc++)
            step(!((cyc % 7) == 3 || (cyc >= 400 && cyc < 406)));
        // Mid-run reset with a full array in flight (R7).
        rst_n = 1'b0;
        line_adv = 1'b1;
        repeat (2) @(negedge clk);
        check_reset();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule